// File: doc/BRIEF.md
# Flash bank bit-7 write-status responder

This block produces the value a flash bank places on data bit 7 while an internal program or erase algorithm runs, and it drives the bank's hardware ready/busy line. A command controller reports the bank's algorithm state on `op_i` and pulses `cmd_end_i` in the cycle that ends the last write pulse of a command sequence. From that pulse on, reads of bit 7 return status rather than array data. During a program, the read returns the inverse of the bit being written. During an erase, it returns a fixed 0. A fixed 1 marks a finished erase or an erase-suspended bank. After a program finishes, the first read returns the true written bit.

When a command targets protected storage, the block shows the same status for a fixed window and then falls back to read mode by itself. This happens whatever `op_i` does in the meantime. The window is one length for a program and a longer length for an erase. Both lengths are parameters given in clock cycles.

The bit-7 output is a register. It loads only on a read strobe. Each read returns the value that belongs to the state held before that clock edge.

Top module: `flash_dq7_status`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ready_o` is 1 and `dq7_o` is 0.
- R2: With no armed command (read mode), a read returns `array_bit_i`, even while `op_i` shows an operation. A read in the same cycle as `cmd_end_i` also returns `array_bit_i`.
- R3: The `op_i` codes are idle=0, program=1, erase=2, erase-suspended=3 and program-within-suspend=4. After `cmd_end_i` with code 1 or 4 on an unprotected target, `ready_o` is 0 and reads return the inverse of `prog_bit_i` as it stood at `cmd_end_i`. Later changes of `prog_bit_i` do not affect the result.
- R4: When `op_i` leaves codes 1 and 4 for idle, `ready_o` returns to 1. The first read after that returns the latched programmed bit. Later reads return `array_bit_i`.
- R5: After `cmd_end_i` with code 2 on an unprotected target, or when an erase resumes (`op_i` moves from 3 to 2), `ready_o` is 0 and reads return 0.
- R6: While the bank is erase-suspended (code 3), reads return 1 and `ready_o` is 1. When an erase ends (code 2 to idle), the first read returns 1 and later reads return `array_bit_i`.
- R7: A program command with `prot_i` high holds `ready_o` at 0 for exactly `PROG_WIN_CYC` cycles, regardless of `op_i`. Reads inside the window return the inverted latched bit. Afterwards the block is in read mode.
- R8: An erase command with `prot_i` high holds `ready_o` at 0 for exactly `ERASE_WIN_CYC` cycles. Reads inside the window return 0. Afterwards the block is in read mode.
- R9: A read in the same cycle as the end of a program returns the inverted bit. The next read returns the true bit.
- R10: `dq7_o` changes only in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Bank algorithm state code |
| prog_bit_i | input | 1 | Bit-7 value being programmed |
| prot_i | input | 1 | Target sector(s) protected |
| cmd_end_i | input | 1 | End of the final write pulse of a command |
| rd_i | input | 1 | Read strobe |
| array_bit_i | input | 1 | Stored array bit 7 for read mode |
| dq7_o | output | 1 | Bit-7 read value, registered on the read strobe |
| ready_o | output | 1 | Ready/busy, low while busy |

## Verification
Two events can land in the same cycle as a read strobe. One is the command-end pulse. The other is the drop of `op_i` that ends a program. The bench raises the read strobe on exactly those cycles and expects the value that belongs to the earlier state: the array bit for the command-end case, the inverted bit for the completion case. The true bit must then appear on the very next read. The scoreboard queues each expected read value when the strobe is driven and compares it one cycle later. This separates a design that switches early from one that switches a cycle late.

// File: rtl/dq7_status_pkg.sv
`timescale 1ns/1ps
package dq7_status_pkg;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_PROG      = 3'd1,
        OP_ERASE     = 3'd2,
        OP_SUSP      = 3'd3,
        OP_SUSP_PROG = 3'd4
    } bank_op_e;

    typedef enum logic [2:0] {
        ST_READ  = 3'd0,
        ST_PBUSY = 3'd1,
        ST_EBUSY = 3'd2,
        ST_SUSP  = 3'd3,
        ST_DONE  = 3'd4,
        ST_PWIN  = 3'd5
    } dq7_st_e;

    function automatic logic op_is_prog(bank_op_e op);
        return (op == OP_PROG) || (op == OP_SUSP_PROG);
    endfunction

    function automatic logic st_is_busy(dq7_st_e s);
        return (s == ST_PBUSY) || (s == ST_EBUSY) || (s == ST_PWIN);
    endfunction

endpackage

// File: rtl/dq7_win_timer.sv
`timescale 1ns/1ps
module dq7_win_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dq7_ctrl_fsm.sv
`timescale 1ns/1ps
module dq7_ctrl_fsm
    import dq7_status_pkg::*;
#(
    parameter int PROG_WIN_CYC  = 200,
    parameter int ERASE_WIN_CYC = 20000,
    parameter int CNT_W         = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_op_e         op,
    input  logic             prog_bit,
    input  logic             prot,
    input  logic             cmd_end,
    input  logic             rd,
    input  logic             win_expired,
    output dq7_st_e          st,
    output logic             pbit_q,
    output logic             done_q,
    output logic             win_erase_q,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);
    localparam logic [CNT_W-1:0] PW_LOAD = CNT_W'(PROG_WIN_CYC - 1);
    localparam logic [CNT_W-1:0] EW_LOAD = CNT_W'(ERASE_WIN_CYC - 1);

    dq7_st_e st_n;
    logic    pbit_n, done_n, win_erase_n;
    logic    can_arm, op_starts, arm;
    logic    is_erase;

    always_comb begin
        is_erase  = (op == OP_ERASE);
        op_starts = op_is_prog(op) || is_erase;
        can_arm   = (st == ST_READ) || (st == ST_DONE) ||
                    ((st == ST_SUSP) && (op == OP_SUSP_PROG));
        arm       = cmd_end && can_arm && op_starts;
    end

    always_comb begin
        st_n        = st;
        pbit_n      = pbit_q;
        done_n      = done_q;
        win_erase_n = win_erase_q;
        tmr_load    = 1'b0;
        tmr_val     = is_erase ? EW_LOAD : PW_LOAD;
        if (arm) begin
            pbit_n      = prog_bit;
            win_erase_n = is_erase;
            if (prot) begin
                st_n     = ST_PWIN;
                tmr_load = 1'b1;
            end else begin
                st_n = is_erase ? ST_EBUSY : ST_PBUSY;
            end
        end else begin
            case (st)
                ST_PBUSY: begin
                    if (!op_is_prog(op)) begin
                        st_n   = (op == OP_SUSP) ? ST_SUSP : ST_DONE;
                        done_n = pbit_q;
                    end
                end
                ST_EBUSY: begin
                    if (op == OP_SUSP) begin
                        st_n = ST_SUSP;
                    end else if (op != OP_ERASE) begin
                        st_n   = ST_DONE;
                        done_n = 1'b1;
                    end
                end
                ST_SUSP: begin
                    if (op == OP_ERASE) begin
                        st_n = ST_EBUSY;
                    end else if (op == OP_IDLE) begin
                        st_n = ST_READ;
                    end
                end
                ST_DONE: begin
                    if (rd) st_n = ST_READ;
                end
                ST_PWIN: begin
                    if (win_expired) st_n = ST_READ;
                end
                default: st_n = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_READ;
            pbit_q      <= 1'b0;
            done_q      <= 1'b0;
            win_erase_q <= 1'b0;
        end else begin
            st          <= st_n;
            pbit_q      <= pbit_n;
            done_q      <= done_n;
            win_erase_q <= win_erase_n;
        end
    end
endmodule

// File: rtl/dq7_out_sel.sv
`timescale 1ns/1ps
module dq7_out_sel
    import dq7_status_pkg::*;
(
    input  dq7_st_e st,
    input  logic    array_bit,
    input  logic    pbit_q,
    input  logic    done_q,
    input  logic    win_erase_q,
    output logic    bit_val,
    output logic    ready
);
    always_comb begin
        case (st)
            ST_READ:  bit_val = array_bit;
            ST_PBUSY: bit_val = ~pbit_q;
            ST_EBUSY: bit_val = 1'b0;
            ST_SUSP:  bit_val = 1'b1;
            ST_DONE:  bit_val = done_q;
            ST_PWIN:  bit_val = win_erase_q ? 1'b0 : ~pbit_q;
            default:  bit_val = array_bit;
        endcase
        ready = ~st_is_busy(st);
    end
endmodule

// File: rtl/flash_dq7_status.sv
`timescale 1ns/1ps
module flash_dq7_status
    import dq7_status_pkg::*;
#(
    parameter int PROG_WIN_CYC  = 200,
    parameter int ERASE_WIN_CYC = 20000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] op_i,
    input  logic       prog_bit_i,
    input  logic       prot_i,
    input  logic       cmd_end_i,
    input  logic       rd_i,
    input  logic       array_bit_i,
    output logic       dq7_o,
    output logic       ready_o
);
    localparam int MAX_WIN = (PROG_WIN_CYC > ERASE_WIN_CYC) ? PROG_WIN_CYC : ERASE_WIN_CYC;
    localparam int CNT_W   = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;

    bank_op_e         op;
    dq7_st_e          st;
    logic             pbit_q, done_q, win_erase_q;
    logic             tmr_load, win_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             bit_val, ready_c;

    assign op = bank_op_e'(op_i);

    dq7_ctrl_fsm #(
        .PROG_WIN_CYC (PROG_WIN_CYC),
        .ERASE_WIN_CYC(ERASE_WIN_CYC),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .prog_bit   (prog_bit_i),
        .prot       (prot_i),
        .cmd_end    (cmd_end_i),
        .rd         (rd_i),
        .win_expired(win_expired),
        .st         (st),
        .pbit_q     (pbit_q),
        .done_q     (done_q),
        .win_erase_q(win_erase_q),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val)
    );

    dq7_win_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .run     (st == ST_PWIN),
        .expired (win_expired)
    );

    dq7_out_sel u_sel (
        .st         (st),
        .array_bit  (array_bit_i),
        .pbit_q     (pbit_q),
        .done_q     (done_q),
        .win_erase_q(win_erase_q),
        .bit_val    (bit_val),
        .ready      (ready_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dq7_o <= 1'b0;
        end else if (rd_i) begin
            dq7_o <= bit_val;
        end
    end

    assign ready_o = ready_c;
endmodule

// File: rtl/flash_dq7_status_chk.sv
`timescale 1ns/1ps
module flash_dq7_status_chk
    import dq7_status_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    rd_i,
    input logic    array_bit_i,
    input logic    dq7_o,
    input logic    ready_o,
    input dq7_st_e st,
    input logic    pbit_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (ready_o && !dq7_o));

    // R10
    hold_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(dq7_o));

    // R2
    read_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ && rd_i) |=> (dq7_o == $past(array_bit_i)));

    // R3
    prog_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PBUSY && rd_i) |=> (dq7_o == !$past(pbit_q)));

    // R5
    erase_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EBUSY && rd_i) |=> !dq7_o);

    // R6
    suspend_one_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSP && rd_i) |=> (dq7_o && ready_o));
endmodule

bind flash_dq7_status flash_dq7_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_i       (rd_i),
    .array_bit_i(array_bit_i),
    .dq7_o      (dq7_o),
    .ready_o    (ready_o),
    .st         (st),
    .pbit_q     (pbit_q)
);

// File: tb/flash_dq7_status_test.sv
`timescale 1ns/1ps
module flash_dq7_status_test;
    import dq7_status_pkg::*;

    localparam int PW = 6;
    localparam int EW = 11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_i = OP_IDLE;
    logic       prog_bit_i = 1'b0;
    logic       prot_i = 1'b0;
    logic       cmd_end_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       array_bit_i = 1'b0;
    logic       dq7_o, ready_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit    exp_q[$];
    string tag_q[$];
    logic  rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    flash_dq7_status #(.PROG_WIN_CYC(PW), .ERASE_WIN_CYC(EW)) uut (
        .clk(clk), .rst(rst), .op_i(op_i), .prog_bit_i(prog_bit_i),
        .prot_i(prot_i), .cmd_end_i(cmd_end_i), .rd_i(rd_i),
        .array_bit_i(array_bit_i), .dq7_o(dq7_o), .ready_o(ready_o)
    );

    always @(posedge clk) rd_seen <= rd_i;

    // monitor: compares each read result one cycle after its strobe
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read result dq7=%0b", dq7_o);
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (dq7_o !== e) begin
                    fails++;
                    $display("FAIL %s: dq7 actual=%0b expected=%0b", t, dq7_o, e);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_read(input bit e, input string t);
        rd_i = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        tick();
        rd_i = 1'b0;
    endtask

    task automatic check_val(input string t, input int act, input int e);
        checks++;
        if (act != e) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, e);
        end
    endtask

    task automatic command(input logic [2:0] op, input bit pbit, input bit prot);
        op_i = op; prog_bit_i = pbit; prot_i = prot; cmd_end_i = 1'b1;
        tick();
        cmd_end_i = 1'b0; prot_i = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (ready_o == 1'b0 && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) tick();
        // R1: still in reset
        check_val("R1 ready in reset", int'(ready_o), 1);
        check_val("R1 dq7 in reset", int'(dq7_o), 0);
        rst = 1'b0;
        tick();
        check_val("R1 ready after reset", int'(ready_o), 1);
        check_val("R1 dq7 after reset", int'(dq7_o), 0);

        // R2: read mode
        array_bit_i = 1'b1; do_read(1'b1, "R2 array one");
        array_bit_i = 1'b0; do_read(1'b0, "R2 array zero");
        op_i = OP_PROG; prog_bit_i = 1'b1; tick();
        do_read(1'b0, "R2 op shown but not armed");
        cmd_end_i = 1'b1;
        do_read(1'b0, "R2 read with command end");
        cmd_end_i = 1'b0;

        // R3: program busy, latched bit
        check_val("R3 busy", int'(ready_o), 0);
        prog_bit_i = 1'b0;
        do_read(1'b0, "R3 inverted latched bit");

        // R9 / R4: completion clash then true data
        op_i = OP_IDLE;
        do_read(1'b0, "R9 read at completion");
        do_read(1'b1, "R4 true bit after program");
        do_read(1'b0, "R4 back to array");
        check_val("R4 ready after program", int'(ready_o), 1);

        // R5 / R6: erase, suspend, program in suspend, resume
        command(OP_ERASE, 1'b1, 1'b0);
        check_val("R5 busy erase", int'(ready_o), 0);
        array_bit_i = 1'b1;
        do_read(1'b0, "R5 erase reads zero");
        array_bit_i = 1'b0;
        op_i = OP_SUSP; tick();
        check_val("R6 ready in suspend", int'(ready_o), 1);
        do_read(1'b1, "R6 suspend reads one");
        command(OP_SUSP_PROG, 1'b0, 1'b0);
        check_val("R3 busy suspend program", int'(ready_o), 0);
        do_read(1'b1, "R3 suspend program inverted");
        op_i = OP_SUSP; tick();
        do_read(1'b1, "R6 suspend again");
        op_i = OP_ERASE; tick();
        check_val("R5 busy after resume", int'(ready_o), 0);
        do_read(1'b0, "R5 resumed erase");
        op_i = OP_IDLE; tick();
        check_val("R6 ready after erase", int'(ready_o), 1);
        do_read(1'b1, "R6 erase done reads one");
        do_read(1'b0, "R6 back to array");

        // R10: no read, no change
        array_bit_i = 1'b1; tick(); tick();
        check_val("R10 dq7 held without read", int'(dq7_o), 0);
        do_read(1'b1, "R10 read picks up array");

        // R7: protected program window
        command(OP_PROG, 1'b1, 1'b1);
        op_i = OP_IDLE;
        count_busy(n);
        check_val("R7 program window length", n, PW);
        do_read(1'b1, "R7 read mode after window");
        command(OP_PROG, 1'b1, 1'b1);
        op_i = OP_IDLE;
        do_read(1'b0, "R7 inverted bit in window");
        count_busy(n);
        do_read(1'b1, "R7 array after window");

        // R8: protected erase window
        command(OP_ERASE, 1'b1, 1'b1);
        op_i = OP_PROG;
        count_busy(n);
        check_val("R8 erase window length", n, EW);
        op_i = OP_IDLE;
        command(OP_ERASE, 1'b1, 1'b1);
        op_i = OP_IDLE;
        do_read(1'b0, "R8 zero in window");
        count_busy(n);
        array_bit_i = 1'b0;
        do_read(1'b0, "R8 array after window");

        tick(); tick();
        check_val("scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule